// File: doc/BRIEF.md
# Address Line Walking XOR Tester

This controller finds address lines that are stuck or shorted together. It takes one test word in a memory region and walks a single set bit through the address, starting just above the byte-offset bits. For each step the partner word is the test address with that one bit flipped. If two addresses that differ in one bit reach the same storage cell, a write to one of them shows up at the other.

For every partner inside the region, the controller does three things in order. It reads the partner. It writes the complement of that value to the test word. It then reads the partner a second time. If the second read returns the value just written to the test word, the two addresses alias and a fault is reported. The value written is held in a register, so the test word is never read back.

A start pulse runs the walk twice. The first run uses the lowest word of the region as the test word, and the second run uses the highest word. A one-cycle done pulse follows the second run, together with a pass flag and the first failing test/partner/mask triple.

Top module: `addr_walk_tester`

## Requirements
- R1: While reset is asserted and after it is released, `done_o`, `pass_o`, `busy_o`, `mem_req_o` and `mem_we_o` are low.
- R2: The XOR masks take the values WORD_BYTES, 2*WORD_BYTES, and so on, doubling each step, up to and including 2^(ADDR_W-1). WORD_BYTES is DATA_W/8. The memory accesses appear in ascending mask order.
- R3: A partner (test address XOR mask) is accessed only when base <= partner < base + size. A step whose partner falls outside that range makes no memory access.
- R4: For each partner in range there are exactly three accesses, in this order: a read of the partner, a write to the test address whose data is the bitwise complement of the data returned by that first read, and a second read of the partner.
- R5: A fault is recorded when the second read of a partner returns the value written to the test address. The first fault of a start is kept on `fail_test_o`, `fail_partner_o` and `fail_mask_o`.
- R6: The first run uses `base_i` as the test address. The second run uses `base_i + size_i - WORD_BYTES`.
- R7: `done_o` is high for exactly one cycle, at the cycle `busy_o` falls after the second run. `pass_o` is then high only if neither run found a fault, and `pass_o` holds its value until the next start.
- R8: `start_i` has no effect while `busy_o` is high.
- R9: `mem_we_o` is high only together with `mem_req_o`. Every address driven on the port is word aligned: its low log2(WORD_BYTES) bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse that begins the two runs |
| base_i | input | ADDR_W | Byte address of the region's first word |
| size_i | input | ADDR_W+1 | Region length in bytes |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | One-cycle pulse at the end of the test |
| pass_o | output | 1 | No aliasing found in either run |
| fail_test_o | output | ADDR_W | Test address of the first fault |
| fail_partner_o | output | ADDR_W | Partner address of the first fault |
| fail_mask_o | output | ADDR_W | XOR mask of the first fault |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | ADDR_W | Byte address of the access |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, valid the cycle after a read request |

## Verification
The properties assume the following about the inputs. `base_i` and `size_i` stay fixed while `busy_o` is high. The base is word aligned. The size is a nonzero multiple of the word size. base + size does not exceed the address space. The memory returns read data exactly one cycle after a read request. The bench meets these conditions: it changes base and size only between runs and uses only aligned regions. Its memory model is registered with one cycle of read latency, and stuck-low address bits in that model create the aliasing.

// File: rtl/addr_walk_pkg.sv
package addr_walk_pkg;

  typedef enum logic [2:0] {
    C_IDLE,
    C_CHECK,
    C_RD1,
    C_CAP1,
    C_WR,
    C_RD2,
    C_CAP2
  } core_state_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RUN_LO,
    S_RUN_HI
  } seq_state_e;

endpackage

// File: rtl/addr_walk_mask_gen.sv
module addr_walk_mask_gen #(
  parameter int ADDR_W = 16,
  parameter int LSB    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] mask_o,
  output logic              last_o
);

  logic [ADDR_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (init_i) begin
      mask_q <= ADDR_W'(1) << LSB;
    end else if (step_i) begin
      mask_q <= mask_q << 1;
    end
  end

  assign mask_o = mask_q;
  assign last_o = mask_q[ADDR_W-1];

endmodule

// File: rtl/addr_walk_range_chk.sv
module addr_walk_range_chk #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W:0]   size_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              in_range_o
);

  logic [ADDR_W:0] limit;
  logic            above_base;
  logic            below_limit;

  assign limit       = {1'b0, base_i} + size_i;
  assign above_base  = (addr_i >= base_i);
  assign below_limit = ({1'b0, addr_i} < limit);
  assign in_range_o  = above_base && below_limit;

endmodule

// File: rtl/addr_walk_core.sv
module addr_walk_core
  import addr_walk_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  parameter int LSB    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] test_addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W:0]   size_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              fault_o,
  output logic [ADDR_W-1:0] test_o,
  output logic [ADDR_W-1:0] partner_o,
  output logic [ADDR_W-1:0] mask_o,
  output logic              done_o
);

  core_state_e       state_q, state_d;
  logic [ADDR_W-1:0] test_q;
  logic [DATA_W-1:0] wr_val_q;
  logic              done_q;
  logic [ADDR_W-1:0] mask;
  logic [ADDR_W-1:0] partner;
  logic              last;
  logic              in_range;
  logic              mask_init;
  logic              mask_step;
  logic              finish;

  addr_walk_mask_gen #(.ADDR_W(ADDR_W), .LSB(LSB)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (mask_init),
    .step_i (mask_step),
    .mask_o (mask),
    .last_o (last)
  );

  assign partner = test_q ^ mask;

  addr_walk_range_chk #(.ADDR_W(ADDR_W)) u_range (
    .base_i     (base_i),
    .size_i     (size_i),
    .addr_i     (partner),
    .in_range_o (in_range)
  );

  always_comb begin
    state_d   = state_q;
    mask_init = 1'b0;
    mask_step = 1'b0;
    finish    = 1'b0;
    unique case (state_q)
      C_IDLE: if (start_i) begin
        mask_init = 1'b1;
        state_d   = C_CHECK;
      end
      C_CHECK: begin
        if (in_range) begin
          state_d = C_RD1;
        end else if (last) begin
          finish  = 1'b1;
          state_d = C_IDLE;
        end else begin
          mask_step = 1'b1;
        end
      end
      C_RD1:  state_d = C_CAP1;
      C_CAP1: state_d = C_WR;
      C_WR:   state_d = C_RD2;
      C_RD2:  state_d = C_CAP2;
      C_CAP2: begin
        if (last) begin
          finish  = 1'b1;
          state_d = C_IDLE;
        end else begin
          mask_step = 1'b1;
          state_d   = C_CHECK;
        end
      end
      default: state_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= C_IDLE;
      test_q   <= '0;
      wr_val_q <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
      if (state_q == C_IDLE && start_i) test_q <= test_addr_i;
      // value for the test word is kept so it is never read back
      if (state_q == C_CAP1) wr_val_q <= ~mem_rdata_i;
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = partner;
    mem_wdata_o = wr_val_q;
    unique case (state_q)
      C_RD1, C_RD2: mem_req_o = 1'b1;
      C_WR: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = test_q;
      end
      default: ;
    endcase
  end

  assign fault_o   = (state_q == C_CAP2) && (mem_rdata_i == wr_val_q);
  assign test_o    = test_q;
  assign partner_o = partner;
  assign mask_o    = mask;
  assign done_o    = done_q;

endmodule

// File: rtl/addr_walk_tester.sv
module addr_walk_tester
  import addr_walk_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W:0]   size_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic [ADDR_W-1:0] fail_test_o,
  output logic [ADDR_W-1:0] fail_partner_o,
  output logic [ADDR_W-1:0] fail_mask_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);

  localparam int WORD_BYTES = DATA_W / 8;
  localparam int LSB        = $clog2(WORD_BYTES);

  seq_state_e        state_q;
  logic              core_start;
  logic              core_done;
  logic              core_fault;
  logic [ADDR_W-1:0] core_test_in;
  logic [ADDR_W-1:0] core_test;
  logic [ADDR_W-1:0] core_partner;
  logic [ADDR_W-1:0] core_mask;
  logic [ADDR_W:0]   top_sum;
  logic [ADDR_W-1:0] top_addr;
  logic              fault_seen_q;
  logic              pass_q;
  logic              done_q;
  logic [ADDR_W-1:0] f_test_q, f_partner_q, f_mask_q;

  assign top_sum  = {1'b0, base_i} + size_i - (ADDR_W+1)'(WORD_BYTES);
  assign top_addr = top_sum[ADDR_W-1:0];

  always_comb begin
    core_start   = 1'b0;
    core_test_in = base_i;
    unique case (state_q)
      S_IDLE:   core_start = start_i;
      S_RUN_LO: begin
        core_start   = core_done;
        core_test_in = top_addr;
      end
      default:  ;
    endcase
  end

  addr_walk_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LSB(LSB)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (core_start),
    .test_addr_i (core_test_in),
    .base_i      (base_i),
    .size_i      (size_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .fault_o     (core_fault),
    .test_o      (core_test),
    .partner_o   (core_partner),
    .mask_o      (core_mask),
    .done_o      (core_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_IDLE;
      fault_seen_q <= 1'b0;
      pass_q       <= 1'b0;
      done_q       <= 1'b0;
      f_test_q     <= '0;
      f_partner_q  <= '0;
      f_mask_q     <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          state_q      <= S_RUN_LO;
          fault_seen_q <= 1'b0;
          pass_q       <= 1'b0;
          f_test_q     <= '0;
          f_partner_q  <= '0;
          f_mask_q     <= '0;
        end
        S_RUN_LO: if (core_done) state_q <= S_RUN_HI;
        S_RUN_HI: if (core_done) begin
          state_q <= S_IDLE;
          done_q  <= 1'b1;
          pass_q  <= !fault_seen_q;
        end
        default: state_q <= S_IDLE;
      endcase
      // only the first alias of a start is kept
      if (core_fault && !fault_seen_q) begin
        fault_seen_q <= 1'b1;
        f_test_q     <= core_test;
        f_partner_q  <= core_partner;
        f_mask_q     <= core_mask;
      end
    end
  end

  assign busy_o         = (state_q != S_IDLE);
  assign done_o         = done_q;
  assign pass_o         = pass_q;
  assign fail_test_o    = f_test_q;
  assign fail_partner_o = f_partner_q;
  assign fail_mask_o    = f_mask_q;

endmodule

// File: rtl/addr_walk_tester_chk.sv
module addr_walk_tester_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] base_i,
  input logic [ADDR_W:0]   size_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic [DATA_W-1:0] mem_rdata_i
);

  localparam int LSB = $clog2(DATA_W / 8);

  logic [ADDR_W:0] lim;
  assign lim = {1'b0, base_i} + size_i;

  // R9
  we_with_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_req_o);

  // R9
  addr_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[LSB-1:0] == '0));

  // R3
  read_in_region_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> (mem_addr_o >= base_i) && ({1'b0, mem_addr_o} < lim));

  // R4
  wdata_complement_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_wdata_o == ~$past(mem_rdata_i)));

  // R4
  write_then_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> (mem_req_o && !mem_we_o));

  // R7
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  done_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  // R8
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !done_o) |=> (busy_o || done_o));

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);

endmodule

bind addr_walk_tester addr_walk_tester_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .base_i      (base_i),
  .size_i      (size_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_rdata_i (mem_rdata_i)
);

// File: tb/addr_walk_tester_bench.sv
module addr_walk_tester_bench;

  localparam int AW    = 12;
  localparam int DW    = 64;
  localparam int WORDS = (1 << AW) / 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] base = '0;
  logic [AW:0]   size = '0;
  logic          busy, done, pass;
  logic [AW-1:0] f_test, f_partner, f_mask;
  logic          req, we;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata = '0;

  always #2.5 clk = ~clk;

  addr_walk_tester #(.ADDR_W(AW), .DATA_W(DW)) u_addr_walk_tester (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base), .size_i(size),
    .busy_o(busy), .done_o(done), .pass_o(pass),
    .fail_test_o(f_test), .fail_partner_o(f_partner), .fail_mask_o(f_mask),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr),
    .mem_wdata_o(wdata), .mem_rdata_i(rdata)
  );

  integer checks = 0;
  integer errors = 0;
  integer cycles = 0;

  // memory with stuck-low address bits
  logic [DW-1:0] ram    [WORDS];
  logic [DW-1:0] shadow [WORDS];
  logic [AW-1:0] stuck = '0;

  function automatic int idx(input logic [AW-1:0] a, input logic [AW-1:0] s);
    logic [AW-1:0] m;
    m = a & ~s;
    return int'(m[AW-1:3]);
  endfunction

  always @(posedge clk) begin
    if (req) begin
      if (we) ram[idx(addr, stuck)] <= wdata;
      else    rdata <= ram[idx(addr, stuck)];
    end
  end

  typedef struct {
    bit            we;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
  } txn_t;

  txn_t          exp_q[$];
  bit            exp_pass;
  logic [AW-1:0] exp_t, exp_p, exp_m;

  task automatic chk(input bit ok, input string req_s, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req_s, what, act, expv);
    end
  endtask

  task automatic init_mem();
    for (int i = 0; i < WORDS; i++) begin
      ram[i]    = {32'(i) * 32'h9e3779b9, ~32'(i)};
      shadow[i] = ram[i];
    end
  endtask

  // behavioural expectation of the whole transaction stream
  task automatic build_expect(input int b, input int sz);
    bit seen = 0;
    exp_q.delete();
    for (int run = 0; run < 2; run++) begin
      int t = (run == 0) ? b : b + sz - 8;
      for (int m = 8; m < (1 << AW); m = m * 2) begin
        int p = t ^ m;
        if (p >= b && p < b + sz) begin
          logic [DW-1:0] v, r;
          txn_t x;
          v = shadow[idx(AW'(p), stuck)];
          x.we = 0; x.addr = AW'(p); x.wdata = '0; exp_q.push_back(x);
          x.we = 1; x.addr = AW'(t); x.wdata = ~v; exp_q.push_back(x);
          shadow[idx(AW'(t), stuck)] = ~v;
          x.we = 0; x.addr = AW'(p); x.wdata = '0; exp_q.push_back(x);
          r = shadow[idx(AW'(p), stuck)];
          if (r == ~v && !seen) begin
            seen = 1; exp_t = AW'(t); exp_p = AW'(p); exp_m = AW'(m);
          end
        end
      end
    end
    exp_pass = !seen;
  endtask

  // per-clock comparison of the memory port against the model
  always @(negedge clk) begin
    if (rst_n && req) begin
      if (exp_q.size() == 0) begin
        chk(0, "R3", "unexpected access", {52'd0, addr}, 64'd0);
      end else begin
        txn_t x;
        x = exp_q.pop_front();
        chk(we == x.we, "R4", "access kind", 64'(we), 64'(x.we));
        chk(addr == x.addr, "R2 R3 R6", "access address", 64'(addr), 64'(x.addr));
        if (x.we) chk(wdata == x.wdata, "R4", "write data", wdata, x.wdata);
        chk(addr[2:0] == 3'd0, "R9", "alignment", 64'(addr), 64'(addr & ~12'h7));
      end
    end
    if (rst_n && we && !req) chk(0, "R9", "we without req", 64'(we), 64'd0);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run_case(input string name, input int b, input int sz,
                          input logic [AW-1:0] s, input bit poke_start);
    int dones = 0;
    int wait_c = 0;
    @(negedge clk);
    stuck = s;
    base  = AW'(b);
    size  = (AW+1)'(sz);
    init_mem();
    build_expect(b, sz);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke_start) begin
      repeat (4) @(negedge clk);
      start = 1'b1;  // R8: must be ignored
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && wait_c < 20000) begin
      @(negedge clk);
      wait_c++;
    end
    if (done) dones++;
    chk(done == 1'b1, "R7", {name, " done seen"}, 64'(done), 64'd1);
    chk(busy == 1'b0, "R7", {name, " idle at done"}, 64'(busy), 64'd0);
    chk(pass == exp_pass, "R5 R7", {name, " pass"}, 64'(pass), 64'(exp_pass));
    if (!exp_pass) begin
      chk(f_test == exp_t, "R5", {name, " fail test"}, 64'(f_test), 64'(exp_t));
      chk(f_partner == exp_p, "R5", {name, " fail partner"}, 64'(f_partner), 64'(exp_p));
      chk(f_mask == exp_m, "R5", {name, " fail mask"}, 64'(f_mask), 64'(exp_m));
    end
    repeat (6) begin
      @(negedge clk);
      if (done) dones++;
    end
    chk(dones == 1, "R7", {name, " done pulses"}, 64'(dones), 64'd1);
    chk(pass == exp_pass, "R7", {name, " pass held"}, 64'(pass), 64'(exp_pass));
    chk(exp_q.size() == 0, "R2 R4", {name, " accesses left"}, 64'(exp_q.size()), 64'd0);
    chk(busy == 1'b0, "R8", {name, " no restart"}, 64'(busy), 64'd0);
  endtask

  initial begin
    init_mem();
    repeat (3) @(negedge clk);
    // R1
    chk(!done && !pass && !busy && !req && !we, "R1", "outputs in reset",
        {59'd0, done, pass, busy, req, we}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!done && !pass && !busy && !req && !we, "R1", "outputs after reset",
        {59'd0, done, pass, busy, req, we}, 64'd0);

    run_case("full_clean", 0, 'h1000, '0, 1'b0);          // R2 R4 R6
    run_case("mid_region", 'h100, 'h200, '0, 1'b0);       // R3 R6
    run_case("skip_edges", 'h018, 'h40, '0, 1'b0);        // R3: below base and at end
    run_case("stuck_bit6", 0, 'h1000, 12'h040, 1'b0);     // R5
    chk(exp_m == 12'h040, "R5", "model mask for bit 6", 64'(exp_m), 64'h40);
    run_case("alias_outside", 'h800, 'h800, 12'h800, 1'b0); // R3: alias only outside
    run_case("start_busy", 'h200, 'h400, '0, 1'b1);       // R8
    run_case("stuck_bit3_hi", 'h400, 'h400, 12'h008, 1'b1); // R5 R8

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule